// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a small processor core with one accumulator and a single word-wide memory that holds both the program and its data. Each instruction is one 16-bit word: the upper four bits select the operation and the lower twelve bits give a direct word address. The core walks every instruction through explicit register transfers. The program counter is copied to the address register. The addressed word is read into the buffer register. The buffer register then goes to the instruction register, or the operand goes on to the accumulator.

The memory is an internal synchronous array with one cycle of read latency. While the core is held in reset, a preload port writes program and data words into that array. After reset is released, execution starts at a parameterised start address. It runs until a halt instruction is met. At the end of every instruction the controller passes through an interrupt-check state. That state acknowledges a pending request and then goes on to the next fetch at the normal address, with no vectoring.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, `pc_q` equals the start address (default 0x300), `acc_q` is 0, and `halted`, `st_we` and `irq_ack` are all low.
- R2: A fetch takes four clock edges after the fetch begins. On the fourth edge, `ir_q` takes the memory word at the old `pc_q`, and `pc_q` increments by exactly 1. At no other time does `pc_q` change.
- R3: Opcode 0x1 (bits 15:12) loads `acc_q` with the memory word at the address in bits 11:0.
- R4: Opcode 0x5 adds the memory word at bits 11:0 to `acc_q`, modulo 2^16 (0xFFFF + 0x0002 gives 0x0001).
- R5: Opcode 0x2 writes `acc_q` to the memory word at bits 11:0. `st_we` is high for exactly one cycle, with `st_addr` equal to the address field and `st_data` equal to `acc_q`, and `acc_q` is unchanged.
- R6: Opcode 0xF raises `halted`. Once raised, `halted` stays high and `pc_q` stays constant until reset, and no further store occurs.
- R7: Every other opcode (0x0, 0x3, 0x4, 0x6 to 0xE) changes neither `acc_q` nor memory.
- R8: In the interrupt-check state at the end of each non-halt instruction, `irq_ack` is high for one cycle when `irq_req` is high, and only then. Execution then continues at the sequential `pc_q`.
- R9: Counted from the start of one fetch to the start of the next, a load or add takes 9 cycles, a store takes 7 and an undefined opcode takes 6. A halt raises `halted` 5 cycles after its fetch begins.
- R10: The program 0x1940, 0x5941, 0x2941, 0xF000 placed at 0x300 leaves the sum of words 0x940 and 0x941 in word 0x941.
- R11: A word written through the preload port during reset is the value that a later load of that address returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_we | input | 1 | Preload write strobe (use while in reset) |
| pl_addr | input | 12 | Preload word address |
| pl_data | input | 16 | Preload word |
| irq_req | input | 1 | Pending interrupt request |
| irq_ack | output | 1 | Request seen in the interrupt-check state |
| halted | output | 1 | Core has executed a halt |
| st_we | output | 1 | Store write cycle in progress |
| st_addr | output | 12 | Store target address |
| st_data | output | 16 | Store data |
| pc_q | output | 12 | Program counter |
| ir_q | output | 16 | Instruction register |
| acc_q | output | 16 | Accumulator |

## Verification
A corrupted controller state shows up as a wrong cycle count to `halted` or as a missing or doubled `irq_ack`. It becomes visible at the next instruction boundary, within nine cycles. A wrong address or buffer register appears at the store port, or as a wrong `acc_q` after the next load or add. A program counter fault appears in `ir_q` four cycles into the next fetch. Random programs over a small data window are compared against an instruction-level model in the bench, which covers stores, cycle totals, acknowledges and the final registers.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam logic [3:0] OPC_LOAD  = 4'h1;
   localparam logic [3:0] OPC_STORE = 4'h2;
   localparam logic [3:0] OPC_ADD   = 4'h5;
   localparam logic [3:0] OPC_STOP  = 4'hF;

   typedef enum logic [3:0] {
      CS_FADDR,
      CS_FREAD,
      CS_FLATCH,
      CS_FIR,
      CS_DECODE,
      CS_OREAD,
      CS_OLATCH,
      CS_EXEC,
      CS_WRITE,
      CS_ICHK,
      CS_HALT
   } cyc_state_t;

   typedef struct packed {
      logic mar_from_pc;
      logic mar_from_ir;
      logic mbr_from_mem;
      logic mbr_from_acc;
      logic ir_load;
      logic pc_inc;
      logic acc_from_mbr;
      logic acc_from_sum;
      logic mem_write;
   } xfer_t;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[addr] <= wdata;
      rdata <= words[addr];
   end
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [W-1:0] cin;
         assign cin[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a[i] ^ b[i] ^ cin[i];
            if (i < W - 1) begin : g_carry
               assign cin[i+1] = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
            end
         end
      end else begin : g_native
         assign sum = a + b;
      end
   endgenerate
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic             irq_req,
   output xfer_t            ctl,
   output logic             halted,
   output logic             irq_ack
);
   cyc_state_t st, nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= CS_FADDR;
      else        st <= nxt;
   end

   always_comb begin
      ctl = '0;
      nxt = st;
      unique case (st)
         CS_FADDR: begin
            ctl.mar_from_pc = 1'b1;
            nxt = CS_FREAD;
         end
         CS_FREAD:  nxt = CS_FLATCH;
         CS_FLATCH: begin
            ctl.mbr_from_mem = 1'b1;
            nxt = CS_FIR;
         end
         CS_FIR: begin
            ctl.ir_load = 1'b1;
            ctl.pc_inc  = 1'b1;
            nxt = CS_DECODE;
         end
         CS_DECODE: begin
            if (opcode == OPC_LOAD || opcode == OPC_ADD) begin
               ctl.mar_from_ir = 1'b1;
               nxt = CS_OREAD;
            end else if (opcode == OPC_STORE) begin
               ctl.mar_from_ir  = 1'b1;
               ctl.mbr_from_acc = 1'b1;
               nxt = CS_WRITE;
            end else if (opcode == OPC_STOP) begin
               nxt = CS_HALT;
            end else begin
               nxt = CS_ICHK;
            end
         end
         CS_OREAD:  nxt = CS_OLATCH;
         CS_OLATCH: begin
            ctl.mbr_from_mem = 1'b1;
            nxt = CS_EXEC;
         end
         CS_EXEC: begin
            if (opcode == OPC_ADD) ctl.acc_from_sum = 1'b1;
            else                   ctl.acc_from_mbr = 1'b1;
            nxt = CS_ICHK;
         end
         CS_WRITE: begin
            ctl.mem_write = 1'b1;
            nxt = CS_ICHK;
         end
         CS_ICHK:  nxt = CS_FADDR;
         CS_HALT:  nxt = CS_HALT;
         default:  nxt = CS_FADDR;
      endcase
   end

   assign halted  = (st == CS_HALT);
   assign irq_ack = (st == CS_ICHK) && irq_req;
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter int          ADDR_W     = 12,
   parameter int unsigned START_ADDR = 'h300,
   parameter bit          ADD_RIPPLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pl_we,
   input  logic [ADDR_W-1:0] pl_addr,
   input  logic [DATA_W-1:0] pl_data,
   input  logic              irq_req,
   output logic              irq_ack,
   output logic              halted,
   output logic              st_we,
   output logic [ADDR_W-1:0] st_addr,
   output logic [DATA_W-1:0] st_data,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] ir_q,
   output logic [DATA_W-1:0] acc_q
);
   localparam int OPC_W     = DATA_W - ADDR_W;
   localparam int MEM_DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_ADDR);

   generate
      if (OPC_W != 4) begin : g_bad_opc
         $error("acc_core: opcode field must be 4 bits wide");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("acc_core: ADDR_W must be 1..12");
      end
      if (START_ADDR >= MEM_DEPTH) begin : g_bad_start
         $error("acc_core: START_ADDR outside memory");
      end
   endgenerate

   xfer_t             ctl;
   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] mbr_q;
   logic [DATA_W-1:0] mem_rdata;
   logic [DATA_W-1:0] sum;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_we;

   acc_ctrl #(.OPC_W(OPC_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .opcode  (ir_q[DATA_W-1 -: OPC_W]),
      .irq_req (irq_req),
      .ctl     (ctl),
      .halted  (halted),
      .irq_ack (irq_ack)
   );

   assign mem_addr  = pl_we ? pl_addr : mar_q;
   assign mem_wdata = pl_we ? pl_data : mbr_q;
   assign mem_we    = pl_we | ctl.mem_write;

   acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   acc_adder #(.W(DATA_W), .RIPPLE(ADD_RIPPLE)) u_add (
      .a   (acc_q),
      .b   (mbr_q),
      .sum (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= PC_RST;
         mar_q <= '0;
         mbr_q <= '0;
         ir_q  <= '0;
         acc_q <= '0;
      end else begin
         if (ctl.mar_from_pc)       mar_q <= pc_q;
         else if (ctl.mar_from_ir)  mar_q <= ir_q[ADDR_W-1:0];
         if (ctl.mbr_from_mem)      mbr_q <= mem_rdata;
         else if (ctl.mbr_from_acc) mbr_q <= acc_q;
         if (ctl.ir_load)           ir_q  <= mbr_q;
         if (ctl.pc_inc)            pc_q  <= pc_q + 1'b1;
         if (ctl.acc_from_sum)      acc_q <= sum;
         else if (ctl.acc_from_mbr) acc_q <= mbr_q;
      end
   end

   assign st_we   = ctl.mem_write;
   assign st_addr = mar_q;
   assign st_data = mbr_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic              st_we,
   input logic [DATA_W-1:0] st_data,
   input logic [DATA_W-1:0] acc_q,
   input logic [ADDR_W-1:0] pc_q,
   input logic              irq_req,
   input logic              irq_ack
);
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R6
   AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc_q)); // R6
   AST_NO_STORE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !st_we); // R6
   AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |=> !st_we); // R5
   AST_STORE_DATA_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |-> st_data == acc_q); // R5
   AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |=> $stable(acc_q)); // R5
   AST_PC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc_q) |-> pc_q == $past(pc_q) + 1'b1); // R2
   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> irq_req); // R8
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack); // R8
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .halted  (halted),
   .st_we   (st_we),
   .st_data (st_data),
   .acc_q   (acc_q),
   .pc_q    (pc_q),
   .irq_req (irq_req),
   .irq_ack (irq_ack)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
   localparam int DW = 16;
   localparam int AW = 12;
   localparam logic [11:0] START = 12'h300;

   logic clk = 1'b0, rst_n = 1'b0, pl_we = 1'b0, irq_req = 1'b0;
   logic [AW-1:0] pl_addr = '0;
   logic [DW-1:0] pl_data = '0;
   logic irq_ack, halted, st_we;
   logic [AW-1:0] st_addr, pc_q;
   logic [DW-1:0] st_data, ir_q, acc_q;

   always #5 clk = ~clk;

   acc_core #(.DATA_W(DW), .ADDR_W(AW), .START_ADDR(32'h300)) u0 (
      .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
      .irq_req(irq_req), .irq_ack(irq_ack), .halted(halted), .st_we(st_we),
      .st_addr(st_addr), .st_data(st_data), .pc_q(pc_q), .ir_q(ir_q), .acc_q(acc_q)
   );

   int nvec = 0, nerr = 0;
   bit done = 0;
   logic [15:0] bmem [0:4095];
   logic [11:0] got_a [0:255];
   logic [15:0] got_d [0:255];
   logic [11:0] exp_a [0:255];
   logic [15:0] exp_d [0:255];
   int got_n = 0, ack_n = 0, exp_n = 0;

   always @(negedge clk) if (rst_n) begin
      if (st_we && got_n < 256) begin
         got_a[got_n] = st_addr; got_d[got_n] = st_data; got_n++;
      end
      if (irq_ack) ack_n++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [11:0] a, input logic [15:0] d);
      bmem[a] = d;
      @(negedge clk); pl_we = 1'b1; pl_addr = a; pl_data = d;
      @(negedge clk); pl_we = 1'b0;
   endtask

   // instruction-level model: cycles until halted, final acc, executed non-halt count
   task automatic model(output int cyc, output logic [15:0] acc, output int nins,
                        output logic [11:0] pc_end, output logic [15:0] ir_end);
      logic [11:0] pc = START;
      bit stop = 0;
      cyc = 0; acc = 0; nins = 0; exp_n = 0; ir_end = 0;
      for (int k = 0; k < 300 && !stop; k++) begin
         logic [15:0] w = bmem[pc];
         ir_end = w; pc = pc + 1;
         case (w[15:12])
            4'h1: begin acc = bmem[w[11:0]]; cyc += 9; nins++; end
            4'h5: begin acc = acc + bmem[w[11:0]]; cyc += 9; nins++; end
            4'h2: begin bmem[w[11:0]] = acc; exp_a[exp_n] = w[11:0]; exp_d[exp_n] = acc;
                        exp_n++; cyc += 7; nins++; end
            4'hF: begin cyc += 5; stop = 1; end
            default: begin cyc += 6; nins++; end
         endcase
      end
      pc_end = pc;
   endtask

   task automatic run_prog(input string tag);
      int ecyc, enins, cyc;
      logic [15:0] eacc, eir;
      logic [11:0] epc, pc_h;
      model(ecyc, eacc, enins, epc, eir);
      got_n = 0; ack_n = 0; cyc = 0;
      @(negedge clk); rst_n = 1'b1;
      while (!halted && cyc < 5000) begin
         @(posedge clk); @(negedge clk); cyc++;
      end
      chk(halted, {tag, " R6 halt reached"}, halted, 1);
      chk(cyc == ecyc, {tag, " R9 cycles to halt"}, cyc, ecyc);
      chk(acc_q == eacc, {tag, " R3 R4 final acc"}, acc_q, eacc);
      chk(pc_q == epc, {tag, " R2 final pc"}, pc_q, epc);
      chk(ir_q == eir, {tag, " R2 final ir"}, ir_q, eir);
      chk(ack_n == (irq_req ? enins : 0), {tag, " R8 ack count"}, ack_n, irq_req ? enins : 0);
      pc_h = pc_q;
      repeat (6) @(negedge clk);
      chk(halted && pc_q == pc_h, {tag, " R6 stays halted"}, pc_q, pc_h);
      chk(got_n == exp_n, {tag, " R5 store count"}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         chk(got_a[i] == exp_a[i], {tag, " R5 store addr"}, got_a[i], exp_a[i]);
         chk(got_d[i] == exp_d[i], {tag, " R5 store data"}, got_d[i], exp_d[i]);
      end
      @(negedge clk); rst_n = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED1));
      for (int i = 0; i < 4096; i++) bmem[i] = 16'h0;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(pc_q == START, "R1 pc reset", pc_q, START);
      chk(acc_q == 0, "R1 acc reset", acc_q, 0);
      chk(!halted && !st_we && !irq_ack, "R1 flags reset", {halted, st_we, irq_ack}, 0);

      // R10 worked example with fetch stepping (R2)
      put(12'h300, 16'h1940); put(12'h301, 16'h5941); put(12'h302, 16'h2941);
      put(12'h303, 16'hF000); put(12'h940, 16'h1234); put(12'h941, 16'h0F0F);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(pc_q == 12'h300, "R2 pc before ir load", pc_q, 12'h300);
      @(negedge clk);
      chk(ir_q == 16'h1940, "R2 ir after fetch", ir_q, 16'h1940);
      chk(pc_q == 12'h301, "R2 pc incremented", pc_q, 12'h301);
      @(negedge clk); rst_n = 1'b0;
      run_prog("R10 example");
      // R10 R11 read back word 0x941
      put(12'h300, 16'h1941); put(12'h301, 16'hF000);
      run_prog("R10 readback");
      chk(acc_q == 16'h2143, "R10 sum in 0x941", acc_q, 16'h2143);

      // R4 wraparound
      put(12'h950, 16'hFFFF); put(12'h951, 16'h0002);
      put(12'h300, 16'h1950); put(12'h301, 16'h5951); put(12'h302, 16'hF000);
      run_prog("R4 wrap");
      chk(acc_q == 16'h0001, "R4 wrap value", acc_q, 1);

      // R7 undefined opcodes, R11 preload
      put(12'hA00, 16'hBEEF);
      put(12'h300, 16'h1A00); put(12'h301, 16'h3A00); put(12'h302, 16'h0A00);
      put(12'h303, 16'h7A00); put(12'h304, 16'hEA00); put(12'h305, 16'hF000);
      run_prog("R7 undefined");
      chk(acc_q == 16'hBEEF, "R7 acc untouched / R11 preload", acc_q, 16'hBEEF);

      // R8 interrupt request held high
      irq_req = 1'b1;
      put(12'h300, 16'h1940); put(12'h301, 16'h5941); put(12'h302, 16'h2941);
      put(12'h303, 16'hF000);
      run_prog("R8 irq");
      irq_req = 1'b0;

      // random programs
      for (int r = 0; r < 10; r++) begin
         int len = 6 + ($urandom % 10);
         for (int d = 0; d < 8; d++) put(12'hA00 + d[11:0], 16'($urandom));
         for (int p = 0; p < len; p++) begin
            int sel = $urandom % 8;
            logic [3:0] op;
            logic [11:0] a = 12'hA00 + 12'($urandom % 8);
            op = (sel < 2) ? 4'h1 : (sel < 4) ? 4'h5 : (sel < 6) ? 4'h2 :
                 (sel == 6) ? 4'h3 : 4'h0;
            put(START + p[11:0], {op, a});
         end
         put(START + len[11:0], 16'hF000);
         irq_req = r[0];
         run_prog("R3 R5 R9 random");
      end
      irq_req = 1'b0;

      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1;
         nvec++; nerr++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end
endmodule